// File: doc/BRIEF.md
# Slope-Limited Digital Phase-Locked Loop

This block is an all-digital phase-locked loop that runs entirely on the 20 MHz master clock. A 32-bit phase accumulator serves as the oscillator. Its nominal step produces a 16.384 MHz tick stream. A feedback divider counts those ticks with a ratio chosen by a two-bit reference-rate code. Each falling edge of the reference samples the divider position as a signed phase error.

Once per 8 kHz frame, the latest error is scaled and clamped to a fixed bound, then passed through a first-order low-pass. Both steps act at the frame rate, so the corner does not depend on the reference rate. The filter output is added to the nominal step as a signed offset. Because of the clamp, the output phase can never move faster than the chosen slope.

A mode bit, sampled on the rising edge of the frame strobe, selects between tracking the reference and free-running at the nominal step. A lock flag reports a run of consecutive small-error frames. After reset, the first reference falling edge realigns the accumulator and the feedback divider, and releases the downstream hold.

Top module: `slope_dpll`

## Requirements
- R1: `rate_sel` is registered once. The code 00 is reserved and drives `rate_err` to 1 from the next cycle. The codes 01, 10 and 11 drive it to 0 and select the divide ratios `DIV_LO`, `DIV_T1` and `DIV_E1`.
- R2: While `rst_n` is low, `nco_phase` is 0, `nco_tick` is 0, `locked` is 0 and `outs_hold` is 1. Release of the reset takes effect two clock edges after `rst_n` rises.
- R3: The first falling edge of `ref_in` after reset, with a valid rate code, forces `nco_phase` to 0 and clears the feedback count. It also drops `outs_hold` to 0. These effects appear three edges after `ref_in` falls, because the input passes through a two-stage synchronizer. Later edges do not realign.
- R4: Each later falling edge samples the feedback count c, with divide ratio D. The signed lead is c when c < D/2 and c − D otherwise. The correction is −lead·2^`KP_SH`, clamped to ±`SLOPE_LIM`.
- R5: On the edge that detects a rising `frame_stb`, the filter updates if the loop is in Normal mode and a sample arrived during the frame. The state becomes e ← e + x − floor(e/2^`FILT_SH`), and the offset becomes y = floor(e/2^`FILT_SH`). From the next cycle the accumulator step is `NOM_INC` + y.
- R6: A frame that ends without a reference sample leaves the offset unchanged.
- R7: The accumulator step never differs from `NOM_INC` by more than `SLOPE_LIM`.
- R8: `mode_sel` (0 = Normal, 1 = Freerun) is taken only on the edge that detects a rising `frame_stb`. A change between strobes has no effect.
- R9: In Freerun, or with the reserved rate code, the step is exactly `NOM_INC`, the filter state is cleared and reference edges have no effect on the step.
- R10: On return to Normal, the first step after the strobe uses a zero offset.
- R11: `locked` rises on the strobe that ends the `LOCK_FRAMES`-th consecutive Normal frame in which a sample with |lead| ≤ `LOCK_TH` arrived. Any other frame restarts the count, and leaving Normal clears the flag.
- R12: `nco_tick` is high for one cycle exactly when the accumulator wraps, so a tick always comes with a phase lower than the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference input, acted on at falling edges |
| rate_sel | input | 2 | Reference-rate code (00 reserved) |
| mode_sel | input | 1 | 0 Normal, 1 Freerun; taken at frame strobe |
| frame_stb | input | 1 | 8 kHz frame strobe, synchronous to clk |
| nco_phase | output | PW | Phase accumulator value |
| nco_tick | output | 1 | One-cycle pulse on accumulator wrap |
| outs_hold | output | 1 | Holds downstream outputs high until alignment |
| locked | output | 1 | Lock indicator |
| rate_err | output | 1 | Reserved rate code seen |

## Verification
Two functions can act on the same clock edge: a mode change and a filter update. Both happen at the frame strobe, and both depend on whether a reference sample is pending. The bench provokes this by issuing reference edges inside a tracking frame and then strobing with the mode bit set to Freerun. It judges the result by the step measured from `nco_phase`, which must be exactly nominal from the second cycle after the strobe, and by `locked`, which must fall on that very strobe. A second collision is realignment against a pending tick. The bench checks it through `nco_phase` reading 0 on the alignment cycle.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_FREERUN = 1'b1} loop_mode_e;
  localparam logic [1:0] RATE_RSVD = 2'b00;
  localparam logic [1:0] RATE_LO   = 2'b01;
  localparam logic [1:0] RATE_T1   = 2'b10;
  localparam logic [1:0] RATE_E1   = 2'b11;
endpackage

// File: rtl/dpll_refdiv.sv
module dpll_refdiv
  import dpll_pkg::*;
#(
  parameter int DIV_LO = 2048,
  parameter int DIV_T1 = 11,
  parameter int DIV_E1 = 8,
  parameter int CW     = 11,
  parameter int LW     = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_in,
  input  logic [1:0]           rate_q,
  input  logic                 rate_ok,
  input  logic                 tick,
  output logic                 align,
  output logic                 pd_valid,
  output logic signed [LW-1:0] pd_lead
);
  logic [2:0]           sync_q;
  logic                 ref_fall;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 aligned_q, aligned_d;
  logic [LW-1:0]        div_v;
  logic [LW-1:0]        cnt_x;
  logic                 pv_d;
  logic signed [LW-1:0] lead_d;

  always_comb begin
    case (rate_q)
      RATE_T1: div_v = LW'(DIV_T1);
      RATE_E1: div_v = LW'(DIV_E1);
      default: div_v = LW'(DIV_LO);
    endcase
  end

  assign ref_fall = sync_q[2] & ~sync_q[1];
  assign cnt_x    = {1'b0, cnt_q};

  always_comb begin
    cnt_d     = cnt_q;
    aligned_d = aligned_q;
    align     = 1'b0;
    pv_d      = 1'b0;
    lead_d    = pd_lead;
    if (tick) begin
      cnt_d = (cnt_x >= div_v - 1'b1) ? '0 : cnt_q + 1'b1;
    end
    if (ref_fall && rate_ok) begin
      if (!aligned_q) begin
        align     = 1'b1;
        aligned_d = 1'b1;
        cnt_d     = '0;
      end else begin
        pv_d = 1'b1;
        if (cnt_x < (div_v >> 1)) lead_d = $signed(cnt_x);
        else                      lead_d = $signed(cnt_x - div_v);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      cnt_q     <= '0;
      aligned_q <= 1'b0;
      pd_valid  <= 1'b0;
      pd_lead   <= '0;
    end else begin
      sync_q    <= {sync_q[1:0], ref_in};
      cnt_q     <= cnt_d;
      aligned_q <= aligned_d;
      pd_valid  <= pv_d;
      pd_lead   <= lead_d;
    end
  end

  AST_SAMPLE_AFTER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |-> aligned_q) else $error("sample before alignment"); // R3
endmodule

// File: rtl/dpll_limit.sv
module dpll_limit #(
  parameter int LW       = 12,
  parameter int KP_SH    = 16,
  parameter int SLOPE_LIM = 140737,
  parameter int DW       = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_valid,
  input  logic signed [LW-1:0] pd_lead,
  input  logic                 frame,
  output logic                 seen,
  output logic signed [LW-1:0] last_lead,
  output logic signed [DW-1:0] corr
);
  localparam int SW0 = LW + KP_SH + 2;
  localparam int SW  = (SW0 > DW + 1) ? SW0 : DW + 1;
  localparam logic signed [SW-1:0] LIM_P = SW'(SLOPE_LIM);
  localparam logic signed [SW-1:0] LIM_N = -LIM_P;

  logic                 seen_d;
  logic signed [LW-1:0] lead_d;
  logic signed [SW-1:0] lead_ext, scaled;

  always_comb begin
    seen_d = frame ? pd_valid : (seen | pd_valid);
    lead_d = pd_valid ? pd_lead : last_lead;
  end

  always_comb begin
    lead_ext = SW'(last_lead);
    scaled   = -(lead_ext <<< KP_SH);
    if (scaled > LIM_P)      corr = DW'(LIM_P);
    else if (scaled < LIM_N) corr = DW'(LIM_N);
    else                     corr = DW'(scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_lead <= '0;
    end else begin
      seen      <= seen_d;
      last_lead <= lead_d;
    end
  end

  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (corr <= DW'(SLOPE_LIM)) && (corr >= -DW'(SLOPE_LIM))) else $error("clamp out of range"); // R4
endmodule

// File: rtl/dpll_lpf.sv
module dpll_lpf #(
  parameter int DW        = 32,
  parameter int FILT_SH   = 9,
  parameter int SLOPE_LIM = 140737
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame,
  input  logic                 active,
  input  logic                 seen,
  input  logic signed [DW-1:0] corr,
  output logic signed [DW-1:0] offset
);
  localparam int EW = DW + FILT_SH + 2;

  logic signed [EW-1:0] e_q, e_d;
  logic signed [EW-1:0] e_shr;

  assign e_shr  = e_q >>> FILT_SH;
  assign offset = DW'(e_shr);

  always_comb begin
    e_d = e_q;
    if (!active)            e_d = '0;
    else if (frame && seen) e_d = e_q + EW'(corr) - e_shr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= '0;
    else        e_q <= e_d;
  end

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (offset <= DW'(SLOPE_LIM)) && (offset >= -DW'(SLOPE_LIM))) else $error("offset too large"); // R7
  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !seen && active) |=> $stable(offset)) else $error("offset moved without sample"); // R6
endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int            PW      = 32,
  parameter logic [PW-1:0] NOM_INC = 32'hD1B7_1759,
  parameter int            DW      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 align,
  input  logic                 use_off,
  input  logic signed [DW-1:0] offset,
  output logic [PW-1:0]        phase,
  output logic                 tick
);
  logic [PW-1:0] step;
  logic [PW:0]   sum;
  logic [PW-1:0] phase_d;
  logic          tick_d;

  always_comb begin
    step    = use_off ? NOM_INC + PW'(offset) : NOM_INC;
    sum     = {1'b0, phase} + {1'b0, step};
    phase_d = align ? '0 : sum[PW-1:0];
    tick_d  = align ? 1'b0 : sum[PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      phase <= phase_d;
      tick  <= tick_d;
    end
  end

  AST_FREERUN_NOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_off && !align) |=> ((phase - $past(phase)) == NOM_INC)) else $error("free step not nominal"); // R9
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (phase < $past(phase))) else $error("tick without wrap"); // R12
endmodule

// File: rtl/slope_dpll.sv
module slope_dpll
  import dpll_pkg::*;
#(
  parameter int            PW          = 32,
  parameter logic [PW-1:0] NOM_INC     = 32'hD1B7_1759,
  parameter int            DIV_LO      = 2048,
  parameter int            DIV_T1      = 11,
  parameter int            DIV_E1      = 8,
  parameter int            KP_SH       = 16,
  parameter int            SLOPE_LIM   = 140737,
  parameter int            FILT_SH     = 9,
  parameter int            LOCK_TH     = 2,
  parameter int            LOCK_FRAMES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic [1:0]    rate_sel,
  input  logic          mode_sel,
  input  logic          frame_stb,
  output logic [PW-1:0] nco_phase,
  output logic          nco_tick,
  output logic          outs_hold,
  output logic          locked,
  output logic          rate_err
);
  localparam int MAX_A   = (DIV_LO > DIV_T1) ? DIV_LO : DIV_T1;
  localparam int MAX_DIV = (MAX_A > DIV_E1) ? MAX_A : DIV_E1;
  localparam int CW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam int LW      = CW + 1;
  localparam int DW      = PW;
  localparam int LCW     = $clog2(LOCK_FRAMES + 1);

  logic                 rs1_q, srst_n;
  logic                 fs_q, frame;
  loop_mode_e           mode_q, mode_d;
  logic [1:0]           rate_q;
  logic                 normal_active;
  logic                 align, pd_valid, seen;
  logic signed [LW-1:0] pd_lead, last_lead;
  logic [LW-1:0]        lead_mag;
  logic signed [DW-1:0] corr, offset;
  logic [LCW-1:0]       lcnt_q, lcnt_d;
  logic                 locked_d, hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      srst_n <= rs1_q;
    end
  end

  assign frame         = frame_stb & ~fs_q;
  assign normal_active = (mode_q == MODE_NORMAL) && !rate_err;
  assign lead_mag      = last_lead[LW-1] ? LW'(-last_lead) : LW'(last_lead);

  always_comb begin
    mode_d = frame ? loop_mode_e'(mode_sel) : mode_q;
    lcnt_d = lcnt_q;
    if (!normal_active) begin
      lcnt_d = '0;
    end else if (frame) begin
      if (loop_mode_e'(mode_sel) == MODE_FREERUN)     lcnt_d = '0;
      else if (seen && (lead_mag <= LW'(LOCK_TH))) begin
        if (lcnt_q != LCW'(LOCK_FRAMES)) lcnt_d = lcnt_q + 1'b1;
      end else                                         lcnt_d = '0;
    end
    locked_d = (lcnt_d == LCW'(LOCK_FRAMES));
    hold_d   = align ? 1'b0 : outs_hold;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fs_q      <= 1'b0;
      mode_q    <= MODE_NORMAL;
      rate_q    <= RATE_LO;
      rate_err  <= 1'b0;
      lcnt_q    <= '0;
      locked    <= 1'b0;
      outs_hold <= 1'b1;
    end else begin
      fs_q      <= frame_stb;
      mode_q    <= mode_d;
      rate_q    <= rate_sel;
      rate_err  <= (rate_sel == RATE_RSVD);
      lcnt_q    <= lcnt_d;
      locked    <= locked_d;
      outs_hold <= hold_d;
    end
  end

  dpll_refdiv #(.DIV_LO(DIV_LO), .DIV_T1(DIV_T1), .DIV_E1(DIV_E1), .CW(CW), .LW(LW)) u_refdiv (
    .clk(clk), .rst_n(srst_n), .ref_in(ref_in), .rate_q(rate_q), .rate_ok(!rate_err),
    .tick(nco_tick), .align(align), .pd_valid(pd_valid), .pd_lead(pd_lead));

  dpll_limit #(.LW(LW), .KP_SH(KP_SH), .SLOPE_LIM(SLOPE_LIM), .DW(DW)) u_limit (
    .clk(clk), .rst_n(srst_n), .pd_valid(pd_valid), .pd_lead(pd_lead), .frame(frame),
    .seen(seen), .last_lead(last_lead), .corr(corr));

  dpll_lpf #(.DW(DW), .FILT_SH(FILT_SH), .SLOPE_LIM(SLOPE_LIM)) u_lpf (
    .clk(clk), .rst_n(srst_n), .frame(frame), .active(normal_active), .seen(seen),
    .corr(corr), .offset(offset));

  dpll_nco #(.PW(PW), .NOM_INC(NOM_INC), .DW(DW)) u_nco (
    .clk(clk), .rst_n(srst_n), .align(align), .use_off(normal_active), .offset(offset),
    .phase(nco_phase), .tick(nco_tick));

  AST_MODE_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!srst_n)
    !frame |=> $stable(mode_q)) else $error("mode changed between strobes"); // R8
  AST_LOCK_CLEARED: assert property (@(posedge clk) disable iff (!srst_n)
    !normal_active |=> !locked) else $error("locked outside Normal"); // R11
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(outs_hold) |-> (nco_phase == '0)) else $error("hold dropped without alignment"); // R3
endmodule

// File: tb/sim_slope_dpll.sv
module sim_slope_dpll;
  localparam logic [31:0] NOM = 32'hD1B7_1759;
  localparam int LIM = 140737;
  localparam int FSH = 9;

  logic        clk = 1'b0;
  logic        rst_n, ref_in, mode_sel, frame_stb;
  logic [1:0]  rate_sel;
  logic [31:0] nco_phase;
  logic        nco_tick, outs_hold, locked, rate_err;

  always #10 clk = ~clk;

  slope_dpll #(.DIV_LO(64), .DIV_T1(12), .DIV_E1(8), .KP_SH(20), .LOCK_TH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_sel(rate_sel), .mode_sel(mode_sel),
    .frame_stb(frame_stb), .nco_phase(nco_phase), .nco_tick(nco_tick),
    .outs_hold(outs_hold), .locked(locked), .rate_err(rate_err));

  typedef struct {
    int          cyc;
    int          kind;   // 0 step, 1 phase, 2 locked, 3 hold, 4 rate_err
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          slope_en = 1'b0;
  bit          done = 1'b0;
  logic [31:0] prev_phase = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic expect_at(input int k, input int kind, input logic [31:0] v, input string req);
    exp_t it;
    it.cyc = cyc + k; it.kind = kind; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #7;
  endtask

  // monitor: measures the step each cycle and pops due scoreboard items
  always begin
    logic [31:0] st, act;
    exp_t        it;
    @(posedge clk);
    #5;
    cyc++;
    st = nco_phase - prev_phase;
    if (slope_en) begin
      n_chk++;
      if ((int'(st - NOM) > LIM) || (int'(st - NOM) < -LIM)) begin
        n_err++;
        $display("FAIL R7 actual step %0h expected within %0d of %0h", st, LIM, NOM);
      end
      if (nco_tick) chk("R12 wrap with tick", 32'(nco_phase < prev_phase), 32'd1);
    end
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      case (it.kind)
        0: act = st;
        1: act = nco_phase;
        2: act = 32'(locked);
        3: act = 32'(outs_hold);
        default: act = 32'(rate_err);
      endcase
      if (it.cyc < cyc) chk({it.req, " missed"}, 32'd0, 32'd1);
      else              chk(it.req, act, it.val);
    end
    prev_phase = nco_phase;
  end

  initial begin
    longint e, y;
    rst_n = 1'b0; ref_in = 1'b1; rate_sel = 2'b01; mode_sel = 1'b0; frame_stb = 1'b0;
    step(5);
    chk("R2 phase in reset", nco_phase, 32'd0);
    chk("R2 tick in reset", 32'(nco_tick), 32'd0);
    chk("R2 locked in reset", 32'(locked), 32'd0);
    chk("R2 hold in reset", 32'(outs_hold), 32'd1);
    rst_n = 1'b1;
    step(6);
    chk("R2 hold until alignment", 32'(outs_hold), 32'd1);
    expect_at(1, 0, NOM, "R9 step nominal before alignment");
    step(2);
    // R3: first falling edge realigns
    ref_in = 1'b0;
    expect_at(3, 1, 32'd0, "R3 phase zero at alignment");
    expect_at(3, 3, 32'd0, "R3 hold released");
    step(5);
    slope_en = 1'b1;
    // R4/R5: one large lead sample, one strobe
    step(20);
    ref_in = 1'b1; step(3);
    ref_in = 1'b0; step(10);
    e = 0;
    e = e - LIM - (e >>> FSH);
    y = e >>> FSH;
    frame_stb = 1'b1;
    expect_at(1, 0, NOM, "R5 old step before update");
    expect_at(2, 0, NOM + 32'(y), "R4 R5 clamped and filtered step");
    step(1); frame_stb = 1'b0; step(20);
    // R6: frame without a sample holds the offset
    frame_stb = 1'b1;
    expect_at(2, 0, NOM + 32'(y), "R6 offset held without sample");
    step(1); frame_stb = 1'b0; step(3);
    // R11: lock after consecutive qualifying frames
    for (int i = 1; i <= 16; i++) begin
      ref_in = 1'b1; step(3);
      ref_in = 1'b0; step(8);
      frame_stb = 1'b1;
      expect_at(1, 2, 32'(i == 16), "R11 lock count");
      step(1); frame_stb = 1'b0; step(3);
    end
    // R8: mode change between strobes has no effect
    ref_in = 1'b1; step(3);
    ref_in = 1'b0; step(4);
    mode_sel = 1'b1;
    step(10);
    chk("R8 mode not taken between strobes", 32'(locked), 32'd1);
    // mode change and filter update on the same strobe
    frame_stb = 1'b1;
    expect_at(1, 2, 32'd0, "R11 lock cleared on Freerun");
    expect_at(2, 0, NOM, "R9 Freerun step nominal");
    step(1); frame_stb = 1'b0; step(3);
    ref_in = 1'b1; step(3);
    ref_in = 1'b0; step(8);
    frame_stb = 1'b1;
    expect_at(1, 0, NOM, "R9 reference ignored in Freerun");
    expect_at(2, 0, NOM, "R9 reference ignored in Freerun after strobe");
    step(1); frame_stb = 1'b0; step(3);
    // R10: return to Normal starts from zero offset
    mode_sel = 1'b0; step(2);
    frame_stb = 1'b1;
    expect_at(2, 0, NOM, "R10 zero offset on return");
    step(1); frame_stb = 1'b0; step(3);
    // R1: rate code decode
    rate_sel = 2'b00;
    expect_at(1, 4, 32'd1, "R1 reserved code flagged");
    expect_at(2, 0, NOM, "R9 reserved code runs nominal");
    step(4);
    chk("R11 no lock on reserved code", 32'(locked), 32'd0);
    rate_sel = 2'b10;
    expect_at(1, 4, 32'd0, "R1 code 10 valid");
    step(3);
    rate_sel = 2'b11;
    expect_at(1, 4, 32'd0, "R1 code 11 valid");
    step(3);
    rate_sel = 2'b01;
    expect_at(1, 4, 32'd0, "R1 code 01 valid");
    step(5);
    chk("scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule